// File: doc/BRIEF.md
# Cycle-Stealing Four-Channel DMA Controller

This block moves data between a source and a destination on a shared bus. It takes bus cycles only when the processor's traffic leaves them free. Each channel moves one unit, either a byte or a 16-bit word, for each request edge it sees. A unit is moved as one bus read at the source address followed by one bus write at the destination address. Addresses are 20 bits wide. At most one side of a channel advances through memory, which is called the forward side. The other side, or both sides, stay at a fixed address.

Software sets up each channel through a small register port: two pointer registers, a reload value, a live transfer counter and a control word. The counter and the live forward pointer are loaded from the registers on the first transfer after the channel is enabled. After that they are used on their own. When the counter underflows, the channel raises a one-cycle done pulse. In single mode the channel then turns itself off. In repeat mode it reloads and keeps running.

Top module: `steal_dma`

## Requirements
- R1: When several enabled channels have latched requests, the lowest channel index is served first. Arbitration happens only between transfers, so a transfer that has started always finishes before a newly requested channel starts, even one with a lower index.
- R2: A transfer holds `busRd` at the source address until `busReady`, then holds `busWr` at the destination address until `busReady`. The two strobes are never high together. Byte units write `{8'h00, read_data[7:0]}` with `busWord`=0. Word units write all 16 bits with `busWord`=1.
- R3: The forward side's address advances by 1 after each byte unit and by 2 after each word unit, wrapping modulo 2^20. A fixed side always uses its pointer register.
- R4: On the first transfer after enable, the counter (register index 2) is loaded from the reload register (index 3). Each completed unit decrements it. A unit that completes with the counter at 0 is an underflow, so each period moves reload+1 units.
- R5: In single mode (control bit 2 = 0), an underflow clears the enable bit (control bit 0) and leaves the counter reading 16'hFFFF. Later request edges then cause no bus activity.
- R6: In repeat mode (control bit 2 = 1), an underflow copies the reload value into the counter and reloads the forward address from the forward pointer register. The enable bit stays 1.
- R7: `doneIrq[n]` pulses high for exactly one cycle after each underflow of channel n.
- R8: In the control word, bit 3 marks the source as forward and bit 4 marks the destination as forward. A control write with both bits set stores the source as forward and the destination as fixed.
- R9: A pointer register (index 0 is source, index 1 is destination) whose side is forward can always be written. A fixed-side pointer write is dropped while the channel is enabled.
- R10: Every register reads back at any time on `cpuRdata`, addressed by `cpuAddr = {channel[1:0], index[2:0]}`. While the channel is enabled, reading the forward-side pointer returns the live forward address.
- R11: Only rising edges of `reqIn[n]` that arrive while channel n is enabled are latched. Each latched request is cleared when its transfer starts, so one edge gives exactly one transfer.
- R12: After reset, all registers read 0, no bus strobe is active and no done pulse is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cpuWe | input | 1 | Register write strobe |
| cpuAddr | input | 5 | {channel, register index} |
| cpuWdata | input | 20 | Register write data |
| cpuRdata | output | 20 | Register read data (combinational) |
| reqIn | input | 4 | Per-channel request lines, rising edge active |
| busAddr | output | 20 | Bus address for the current phase |
| busRd | output | 1 | Read cycle strobe |
| busWr | output | 1 | Write cycle strobe |
| busWord | output | 1 | 1 for 16-bit unit, 0 for byte unit |
| busWdata | output | 16 | Write data |
| busRdata | input | 16 | Read data |
| busReady | input | 1 | Completes the current bus phase |
| doneIrq | output | 4 | Per-channel underflow pulse |

## Verification
A corrupted forward pointer shows on the very next write as a wrong destination address, or as wrong data when the source is the forward side. A miscounted transfer counter shows only at the end of a period: the done pulse comes one unit early or late, and a single-mode channel keeps or loses its enable bit at the wrong moment. A stuck or doubled pending latch shows within a few cycles as a write the scoreboard did not expect, or as an expected write that never arrives. The bench compares every bus write in order against the predicted address, data and width. It checks counters, pointers and control words through the register port at the period boundaries.

// File: rtl/cdma_pkg.sv
`timescale 1ns/1ps
package cdma_pkg;
  localparam int CH_SEL_W = 2;
  localparam int REG_W    = 3;
  localparam int CPU_AW   = CH_SEL_W + REG_W;

  localparam int CTL_EN   = 0;
  localparam int CTL_WORD = 1;
  localparam int CTL_RPT  = 2;
  localparam int CTL_SRCF = 3;
  localparam int CTL_DSTF = 4;

  typedef enum logic [REG_W-1:0] {
    REG_SRC = 3'd0,
    REG_DST = 3'd1,
    REG_CNT = 3'd2,
    REG_RLD = 3'd3,
    REG_CTL = 3'd4
  } regSel_e;

  typedef struct packed {
    logic [CH_SEL_W-1:0] chan;
    logic                start;
    logic                rdPhase;
    logic                capture;
    logic                wrPhase;
    logic                finish;
  } ctlStrobe_t;
endpackage

// File: rtl/cdma_ctrl.sv
`timescale 1ns/1ps
module cdma_ctrl
  import cdma_pkg::*;
#(
  parameter int CH_COUNT = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [CH_COUNT-1:0] reqIn,
  input  logic [CH_COUNT-1:0] chanEn,
  input  logic                busReady,
  output ctlStrobe_t          stb,
  output logic                busRd,
  output logic                busWr
);
  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE} phase_e;

  phase_e              state;
  logic [CH_COUNT-1:0] reqPrev;
  logic [CH_COUNT-1:0] pend;
  logic [CH_COUNT-1:0] elig;
  logic [CH_SEL_W-1:0] pick;
  logic [CH_SEL_W-1:0] activeCh;
  logic                found;

  assign elig = pend & chanEn;

  always_comb begin
    pick  = '0;
    found = 1'b0;
    for (int i = CH_COUNT - 1; i >= 0; i--) begin
      if (elig[i]) begin
        pick  = CH_SEL_W'(i);
        found = 1'b1;
      end
    end
  end

  always_comb begin
    stb         = '0;
    stb.chan    = (state == ST_IDLE) ? pick : activeCh;
    stb.start   = (state == ST_IDLE) && found;
    stb.rdPhase = (state == ST_READ);
    stb.capture = (state == ST_READ) && busReady;
    stb.wrPhase = (state == ST_WRITE);
    stb.finish  = (state == ST_WRITE) && busReady;
  end

  assign busRd = (state == ST_READ);
  assign busWr = (state == ST_WRITE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqPrev <= '0;
      pend    <= '0;
    end else begin
      reqPrev <= reqIn;
      for (int i = 0; i < CH_COUNT; i++) begin
        if (!chanEn[i])
          pend[i] <= 1'b0;
        else if (reqIn[i] && !reqPrev[i])
          pend[i] <= 1'b1;
        else if (stb.start && stb.chan == CH_SEL_W'(i))
          pend[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      activeCh <= '0;
    end else begin
      case (state)
        ST_IDLE:  if (found) begin
                    state    <= ST_READ;
                    activeCh <= pick;
                  end
        ST_READ:  if (busReady) state <= ST_WRITE;
        ST_WRITE: if (busReady) state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  // R2: read and write phases never overlap
  a_r2_phase_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(busRd && busWr));
  // R2: a read waits for ready before moving on
  a_r2_read_holds: assert property (@(posedge clk) disable iff (!rstN)
    busRd && !busReady |=> busRd);
  // R1: no lower-index eligible channel is passed over at a start
  a_r1_priority: assert property (@(posedge clk) disable iff (!rstN)
    stb.start |-> ((elig & ((CH_COUNT'(1) << stb.chan) - CH_COUNT'(1))) == '0));
  // R11: a transfer starts only for a latched request
  a_r11_start_pending: assert property (@(posedge clk) disable iff (!rstN)
    stb.start |-> pend[stb.chan]);
endmodule

// File: rtl/cdma_dpath.sv
`timescale 1ns/1ps
module cdma_dpath
  import cdma_pkg::*;
#(
  parameter int CH_COUNT = 4,
  parameter int ADDR_W   = 20,
  parameter int DATA_W   = 16,
  parameter int CNT_W    = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctlStrobe_t          stb,
  input  logic                cpuWe,
  input  logic [CPU_AW-1:0]   cpuAddr,
  input  logic [ADDR_W-1:0]   cpuWdata,
  output logic [ADDR_W-1:0]   cpuRdata,
  input  logic [DATA_W-1:0]   busRdata,
  output logic [ADDR_W-1:0]   busAddr,
  output logic                busWord,
  output logic [DATA_W-1:0]   busWdata,
  output logic [CH_COUNT-1:0] chanEn,
  output logic [CH_COUNT-1:0] doneIrq
);
  localparam int PAD_W = DATA_W - 8;

  logic [ADDR_W-1:0] srcReg [CH_COUNT];
  logic [ADDR_W-1:0] dstReg [CH_COUNT];
  logic [ADDR_W-1:0] fwdPtr [CH_COUNT];
  logic [CNT_W-1:0]  cntReg [CH_COUNT];
  logic [CNT_W-1:0]  rldReg [CH_COUNT];
  logic [CH_COUNT-1:0] en, wordU, rpt, srcF, dstF, fresh;
  logic [DATA_W-1:0] dataHold;

  logic [CH_SEL_W-1:0] cpuCh;
  regSel_e             cpuReg;
  assign cpuCh  = cpuAddr[REG_W +: CH_SEL_W];
  assign cpuReg = regSel_e'(cpuAddr[REG_W-1:0]);
  assign chanEn = en;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < CH_COUNT; i++) begin
        srcReg[i] <= '0;
        dstReg[i] <= '0;
        fwdPtr[i] <= '0;
        cntReg[i] <= '0;
        rldReg[i] <= '0;
      end
      en      <= '0;
      wordU   <= '0;
      rpt     <= '0;
      srcF    <= '0;
      dstF    <= '0;
      fresh   <= '0;
      doneIrq <= '0;
    end else begin
      doneIrq <= '0;
      for (int i = 0; i < CH_COUNT; i++) begin
        if (stb.start && stb.chan == CH_SEL_W'(i) && fresh[i]) begin
          cntReg[i] <= rldReg[i];
          fwdPtr[i] <= srcF[i] ? srcReg[i] : dstReg[i];
          fresh[i]  <= 1'b0;
        end
        if (stb.finish && stb.chan == CH_SEL_W'(i)) begin
          cntReg[i] <= cntReg[i] - CNT_W'(1);
          fwdPtr[i] <= fwdPtr[i] + (wordU[i] ? ADDR_W'(2) : ADDR_W'(1));
          if (cntReg[i] == '0) begin
            doneIrq[i] <= 1'b1;
            if (rpt[i]) begin
              cntReg[i] <= rldReg[i];
              fwdPtr[i] <= srcF[i] ? srcReg[i] : dstReg[i];
            end else begin
              en[i] <= 1'b0;
            end
          end
        end
        if (cpuWe && cpuCh == CH_SEL_W'(i)) begin
          case (cpuReg)
            REG_SRC: if (srcF[i] || !en[i]) srcReg[i] <= cpuWdata;
            REG_DST: if (dstF[i] || !en[i]) dstReg[i] <= cpuWdata;
            REG_RLD: rldReg[i] <= cpuWdata[CNT_W-1:0];
            REG_CTL: begin
              en[i]    <= cpuWdata[CTL_EN];
              wordU[i] <= cpuWdata[CTL_WORD];
              rpt[i]   <= cpuWdata[CTL_RPT];
              srcF[i]  <= cpuWdata[CTL_SRCF];
              dstF[i]  <= cpuWdata[CTL_DSTF] && !cpuWdata[CTL_SRCF];
              if (cpuWdata[CTL_EN] && !en[i]) fresh[i] <= 1'b1;
            end
            default: ;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      dataHold <= '0;
    else if (stb.capture)
      dataHold <= wordU[stb.chan] ? busRdata : {{PAD_W{1'b0}}, busRdata[7:0]};
  end

  always_comb begin
    busAddr = '0;
    busWord = 1'b0;
    for (int i = 0; i < CH_COUNT; i++) begin
      if (stb.chan == CH_SEL_W'(i)) begin
        busWord = wordU[i];
        if (stb.wrPhase)
          busAddr = dstF[i] ? fwdPtr[i] : dstReg[i];
        else
          busAddr = srcF[i] ? fwdPtr[i] : srcReg[i];
      end
    end
  end
  assign busWdata = dataHold;

  always_comb begin
    cpuRdata = '0;
    for (int i = 0; i < CH_COUNT; i++) begin
      if (cpuCh == CH_SEL_W'(i)) begin
        case (cpuReg)
          REG_SRC: cpuRdata = (en[i] && srcF[i]) ? fwdPtr[i] : srcReg[i];
          REG_DST: cpuRdata = (en[i] && dstF[i]) ? fwdPtr[i] : dstReg[i];
          REG_CNT: cpuRdata = ADDR_W'(cntReg[i]);
          REG_RLD: cpuRdata = ADDR_W'(rldReg[i]);
          REG_CTL: cpuRdata = ADDR_W'({dstF[i], srcF[i], rpt[i], wordU[i], en[i]});
          default: ;
        endcase
      end
    end
  end

  // R3: address held steady while a read waits
  a_r3_addr_stable: assert property (@(posedge clk) disable iff (!rstN)
    stb.rdPhase && !stb.capture && !cpuWe |=> $stable(busAddr));

  for (genvar g = 0; g < CH_COUNT; g++) begin : g_chk
    // R8: never both sides forward
    a_r8_one_forward: assert property (@(posedge clk) disable iff (!rstN)
      !(srcF[g] && dstF[g]));
    // R7: done pulse lasts one cycle
    a_r7_irq_pulse: assert property (@(posedge clk) disable iff (!rstN)
      doneIrq[g] |=> !doneIrq[g]);
    // R5: single-mode underflow disables the channel
    a_r5_single_stop: assert property (@(posedge clk) disable iff (!rstN)
      stb.finish && stb.chan == CH_SEL_W'(g) && cntReg[g] == '0 && !rpt[g] && !cpuWe
      |=> !en[g]);
    // R6: repeat-mode underflow reloads the counter and stays enabled
    a_r6_repeat_reload: assert property (@(posedge clk) disable iff (!rstN)
      stb.finish && stb.chan == CH_SEL_W'(g) && cntReg[g] == '0 && rpt[g] && !cpuWe
      |=> en[g] && cntReg[g] == $past(rldReg[g]));
  end
endmodule

// File: rtl/steal_dma.sv
`timescale 1ns/1ps
module steal_dma
  import cdma_pkg::*;
#(
  parameter int CH_COUNT = 4,
  parameter int ADDR_W   = 20,
  parameter int DATA_W   = 16,
  parameter int CNT_W    = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cpuWe,
  input  logic [CPU_AW-1:0]   cpuAddr,
  input  logic [ADDR_W-1:0]   cpuWdata,
  output logic [ADDR_W-1:0]   cpuRdata,
  input  logic [CH_COUNT-1:0] reqIn,
  output logic [ADDR_W-1:0]   busAddr,
  output logic                busRd,
  output logic                busWr,
  output logic                busWord,
  output logic [DATA_W-1:0]   busWdata,
  input  logic [DATA_W-1:0]   busRdata,
  input  logic                busReady,
  output logic [CH_COUNT-1:0] doneIrq
);
  ctlStrobe_t          stb;
  logic [CH_COUNT-1:0] chanEn;

  cdma_ctrl #(.CH_COUNT(CH_COUNT)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .chanEn(chanEn),
    .busReady(busReady), .stb(stb), .busRd(busRd), .busWr(busWr)
  );

  cdma_dpath #(
    .CH_COUNT(CH_COUNT), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .cpuWe(cpuWe), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .cpuRdata(cpuRdata), .busRdata(busRdata),
    .busAddr(busAddr), .busWord(busWord), .busWdata(busWdata),
    .chanEn(chanEn), .doneIrq(doneIrq)
  );
endmodule

// File: tb/steal_dma_bench.sv
`timescale 1ns/1ps
module steal_dma_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cpuWe = 1'b0;
  logic [4:0]  cpuAddr = '0;
  logic [19:0] cpuWdata = '0;
  logic [19:0] cpuRdata;
  logic [3:0]  reqIn = '0;
  logic [19:0] busAddr;
  logic        busRd, busWr, busWord, busReady;
  logic [15:0] busWdata, busRdata;
  logic [3:0]  doneIrq;

  steal_dma u_steal_dma (
    .clk(clk), .rstN(rstN), .cpuWe(cpuWe), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .cpuRdata(cpuRdata), .reqIn(reqIn),
    .busAddr(busAddr), .busRd(busRd), .busWr(busWr), .busWord(busWord),
    .busWdata(busWdata), .busRdata(busRdata), .busReady(busReady),
    .doneIrq(doneIrq)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int failures = 0;
  int writeCount = 0;
  int irqCnt [4] = '{0, 0, 0, 0};
  bit finished = 1'b0;

  typedef struct packed {
    logic [19:0] addr;
    logic [15:0] data;
    logic        word;
  } xfer_t;
  xfer_t expQ [$];

  // bus responder: data derived from address, programmable wait states
  int waitSet = 0;
  int waitCnt = 0;
  assign busReady = (busRd || busWr) && (waitCnt == 0);
  assign busRdata = busRd ? (busAddr[15:0] ^ 16'hA5A5) : 16'h0000;
  always @(posedge clk) begin
    if (!(busRd || busWr) || busReady) waitCnt <= waitSet;
    else waitCnt <= waitCnt - 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN) begin
      for (int c = 0; c < 4; c++) if (doneIrq[c]) irqCnt[c]++;
      if (busWr && busReady) begin
        writeCount++;
        checks++;
        if (expQ.size() == 0) begin
          failures++;
          $display("FAIL R11 unexpected write actual=%h/%h expected=none", busAddr, busWdata);
        end else begin
          xfer_t e;
          e = expQ.pop_front();
          if (busAddr !== e.addr || busWdata !== e.data || busWord !== e.word) begin
            failures++;
            $display("FAIL R2/R3 write actual=%h/%h/%b expected=%h/%h/%b",
                     busAddr, busWdata, busWord, e.addr, e.data, e.word);
          end
        end
      end
    end
  end

  task automatic expectXfer(input logic [19:0] a, input logic [15:0] d, input logic w);
    xfer_t e;
    e.addr = a; e.data = d; e.word = w;
    expQ.push_back(e);
  endtask

  task automatic cpuWrite(input int ch, input int idx, input logic [19:0] d);
    @(negedge clk);
    cpuAddr = {2'(ch), 3'(idx)};
    cpuWdata = d;
    cpuWe = 1'b1;
    @(negedge clk);
    cpuWe = 1'b0;
  endtask

  task automatic cpuRead(input int ch, input int idx, output logic [19:0] d);
    @(negedge clk);
    cpuAddr = {2'(ch), 3'(idx)};
    #1 d = cpuRdata;
  endtask

  task automatic pulse(input logic [3:0] m);
    @(negedge clk);
    reqIn = m;
    @(negedge clk);
    reqIn = '0;
  endtask

  task automatic drain();
    for (int k = 0; k < 200 && expQ.size() != 0; k++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [19:0] rd;
    int wc;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 busRd", busRd, 0);
    chk("R12 busWr", busWr, 0);
    chk("R12 doneIrq", doneIrq, 0);
    rstN = 1'b1;
    cpuRead(0, 4, rd); chk("R12 ctrl", rd, 0);
    cpuRead(2, 2, rd); chk("R12 count", rd, 0);

    // single mode, byte, forward source on channel 1
    waitSet = 2;
    cpuWrite(1, 0, 20'h10000);
    cpuWrite(1, 1, 20'h00300);
    cpuWrite(1, 3, 20'd2);
    cpuWrite(1, 4, 20'h09);
    expectXfer(20'h00300, 16'h00A5, 1'b0);
    expectXfer(20'h00300, 16'h00A4, 1'b0);
    pulse(4'b0010); drain();
    pulse(4'b0010); drain();
    cpuRead(1, 2, rd); chk("R4 count after two units", rd, 0);
    cpuRead(1, 0, rd); chk("R10 R3 live source pointer", rd, 20'h10002);
    chk("R7 no pulse before underflow", irqCnt[1], 0);
    expectXfer(20'h00300, 16'h00A7, 1'b0);
    pulse(4'b0010); drain();
    chk("R7 pulse on underflow", irqCnt[1], 1);
    cpuRead(1, 4, rd); chk("R5 enable cleared", rd, 20'h08);
    cpuRead(1, 2, rd); chk("R5 counter wrapped", rd, 20'h0FFFF);
    cpuRead(1, 0, rd); chk("R10 register when disabled", rd, 20'h10000);
    wc = writeCount;
    pulse(4'b0010);
    repeat (20) @(negedge clk);
    chk("R11 R5 disabled request ignored", writeCount, wc);

    // re-enable: fresh reload of pointer and counter
    cpuWrite(1, 3, 20'd0);
    cpuWrite(1, 4, 20'h09);
    expectXfer(20'h00300, 16'h00A5, 1'b0);
    pulse(4'b0010); drain();
    chk("R4 reload at enable underflow", irqCnt[1], 2);
    cpuRead(1, 4, rd); chk("R5 single stop after reenable", rd, 20'h08);

    // repeat mode, word, forward destination wrapping on channel 2
    waitSet = 0;
    cpuWrite(2, 0, 20'h00400);
    cpuWrite(2, 1, 20'hFFFFC);
    cpuWrite(2, 3, 20'd2);
    cpuWrite(2, 4, 20'h17);
    expectXfer(20'hFFFFC, 16'hA1A5, 1'b1);
    expectXfer(20'hFFFFE, 16'hA1A5, 1'b1);
    expectXfer(20'h00000, 16'hA1A5, 1'b1);
    expectXfer(20'hFFFFC, 16'hA1A5, 1'b1);
    for (int k = 0; k < 4; k++) begin
      pulse(4'b0100); drain();
    end
    chk("R7 R6 one underflow", irqCnt[2], 1);
    cpuRead(2, 4, rd); chk("R6 stays enabled", rd, 20'h17);
    cpuRead(2, 2, rd); chk("R6 counter reloaded", rd, 20'd1);
    cpuRead(2, 1, rd); chk("R10 live destination pointer", rd, 20'hFFFFE);
    cpuWrite(2, 1, 20'h20000);
    cpuWrite(2, 0, 20'h00500);
    cpuRead(2, 0, rd); chk("R9 fixed pointer locked", rd, 20'h00400);
    cpuWrite(2, 4, 20'h16);
    cpuRead(2, 1, rd); chk("R9 forward pointer written", rd, 20'h20000);

    // both-forward coercion
    cpuWrite(3, 4, 20'h18);
    cpuRead(3, 4, rd); chk("R8 destination forced fixed", rd, 20'h08);

    // priority among simultaneous requests
    waitSet = 1;
    cpuWrite(0, 0, 20'h00011); cpuWrite(0, 1, 20'h00A00);
    cpuWrite(0, 3, 20'd5);     cpuWrite(0, 4, 20'h01);
    cpuWrite(1, 3, 20'd5);     cpuWrite(1, 4, 20'h01);
    cpuWrite(3, 0, 20'h00033); cpuWrite(3, 1, 20'h00C00);
    cpuWrite(3, 3, 20'd5);     cpuWrite(3, 4, 20'h01);
    expectXfer(20'h00A00, 16'h00B4, 1'b0);
    expectXfer(20'h00300, 16'h00A5, 1'b0);
    expectXfer(20'h00C00, 16'h0096, 1'b0);
    pulse(4'b1011); drain();
    chk("R1 all served", expQ.size(), 0);

    // no preemption of a running transfer
    waitSet = 3;
    expectXfer(20'h00C00, 16'h0096, 1'b0);
    expectXfer(20'h00A00, 16'h00B4, 1'b0);
    pulse(4'b1000);
    @(negedge clk);
    chk("R2 read phase active", busRd, 1);
    pulse(4'b0001); drain();
    chk("R1 no preemption done", expQ.size(), 0);
    chk("R7 no spurious underflow", irqCnt[0] + irqCnt[3], 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule